// File: doc/BRIEF.md
# Zero-Turnaround Flow-Through Synchronous SRAM

This block is a synthesizable model of a small synchronous static RAM whose bus can alternate between reads and writes on every cycle with no idle slot. Control and address are sampled on one rising clock edge. The data for that operation is on the bus during the cycle that follows. A read drives the addressed word straight from the storage array. A write has its data taken from the bus at the next edge. Because the write commits at the same edge where the following operation is sampled, a read that follows a write to the same word already sees the new contents.

A single address can start a four-beat burst. An internal two-bit counter steps the low address bits in linear or interleaved order. Three chip selects of mixed polarity allow depth expansion. An active-low clock enable freezes the whole block, and an asynchronous output enable can float the bidirectional data bus at any moment. Each 9-bit lane of the 36-bit word has its own write enable.

Top module: `zbl_sram`

## Requirements
- R1: On a rising edge with clk_en_n low, load_n low and all chip selects asserted (sel0_n low, sel1 high, sel2_n low), a new operation starts at addr. wr_n low selects a write and wr_n high selects a read.
- R2: For a read sampled at edge k, dq carries the addressed word during the cycle after edge k. That word includes any write committed at edge k, so reads and writes alternate with no idle cycle.
- R3: While clk_en_n is high, every synchronous input is ignored and the pending operation, burst position and memory are held. A stalled read keeps driving the same word. Write data is taken only at the first edge where clk_en_n is low again.
- R4: load_n low with any chip select inactive starts nothing, ends any burst, and floats dq in the following cycle. A transfer already in its data cycle still completes.
- R5: The block never drives dq during the data cycle of a write. Write data for an operation sampled at edge k is taken from dq at edge k+1.
- R6: oe_n high floats dq at once, without waiting for a clock edge. oe_n low restores the read data.
- R7: Lane i is dq[9i+8:9i]. On a write beat, bw_n[i] low writes that lane and bw_n[i] high leaves it unchanged. bw_n is sampled with every beat.
- R8: load_n high while an operation is active advances the 2-bit beat counter. Chip selects, addr and wr_n are ignored. The read/write kind set at load is kept, and after four beats the counter wraps to the first word.
- R9: seq_lin is sampled at load. When it is high, the low two address bits are (start + beat) mod 4. When it is low, they are start XOR beat. The upper address bits stay fixed during the burst.
- R10: rst high at a rising edge ends any operation, even while the block is stalled, and dq floats in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_en_n | input | 1 | Clock enable, active low; high suspends the block |
| load_n | input | 1 | Low loads a new address, high advances the burst |
| sel0_n | input | 1 | Chip select, active low |
| sel1 | input | 1 | Chip select, active high |
| sel2_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Low for write, high for read, sampled at load |
| bw_n | input | 4 | Per-lane write enables, active low |
| seq_lin | input | 1 | Burst order: 1 linear, 0 interleaved |
| addr | input | 8 | Word address |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq | inout | 36 | Bidirectional data bus |

## Verification
The bench builds the block with 8 address bits and four 9-bit lanes. With these values the address has bits above the burst field that must stay fixed while the low two bits wrap. The lane masks also fall across hex-digit boundaries, so a lane-shift error changes the expected word. The bench lays down one 4-word group with a linear write burst and reads it back with an interleaved burst and a five-beat linear burst that wraps. A floating bus reads as all ones through a pull-up, and no stored test word is all ones.

// File: rtl/zbl_pkg.sv
package zbl_pkg;

    localparam int BURST_BITS = 2;
    localparam int LANE_W_DEF = 9;

    typedef enum logic {
        ORD_XOR = 1'b0,
        ORD_LIN = 1'b1
    } burst_ord_e;

    typedef struct packed {
        logic                  valid;
        logic                  write;
        logic [BURST_BITS-1:0] beat;
        burst_ord_e            ord;
    } op_ctl_t;

    function automatic logic [BURST_BITS-1:0] burst_low(
        input logic [BURST_BITS-1:0] start,
        input logic [BURST_BITS-1:0] beat,
        input burst_ord_e            ord
    );
        logic [BURST_BITS-1:0] r;
        if (ord == ORD_LIN) r = start + beat;
        else                r = start ^ beat;
        return r;
    endfunction

endpackage

// File: rtl/zbl_seq.sv
module zbl_seq
    import zbl_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_en_n,
    input  logic              load_n,
    input  logic              sel0_n,
    input  logic              sel1,
    input  logic              sel2_n,
    input  logic              wr_n,
    input  logic              seq_lin,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  bw_n,
    output logic              op_valid,
    output logic              op_write,
    output logic [ADDR_W-1:0] op_addr,
    output logic [LANES-1:0]  op_be,
    output logic              rd_drive
);

    op_ctl_t           ctl_q, ctl_d;
    logic [ADDR_W-1:0] base_q, base_d;
    logic [LANES-1:0]  be_q, be_d;
    logic              drive_q, drive_d;
    logic              chips_on;

    assign chips_on = !sel0_n && sel1 && !sel2_n;

    always_comb begin
        ctl_d   = ctl_q;
        base_d  = base_q;
        be_d    = be_q;
        drive_d = drive_q;
        if (!clk_en_n) begin
            if (!load_n) begin
                if (chips_on) begin
                    ctl_d = '{valid: 1'b1, write: !wr_n, beat: '0,
                              ord: burst_ord_e'(seq_lin)};
                    base_d  = addr;
                    be_d    = ~bw_n;
                    drive_d = wr_n;
                end else begin
                    ctl_d.valid = 1'b0;
                    drive_d     = 1'b0;
                end
            end else if (ctl_q.valid) begin
                ctl_d.beat = ctl_q.beat + 1'b1;
                be_d       = ~bw_n;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q   <= '0;
            base_q  <= '0;
            be_q    <= '0;
            drive_q <= 1'b0;
        end else begin
            ctl_q   <= ctl_d;
            base_q  <= base_d;
            be_q    <= be_d;
            drive_q <= drive_d;
        end
    end

    assign op_valid = ctl_q.valid;
    assign op_write = ctl_q.write;
    assign op_be    = be_q;
    assign rd_drive = drive_q;
    assign op_addr  = {base_q[ADDR_W-1:BURST_BITS],
                       burst_low(base_q[BURST_BITS-1:0], ctl_q.beat, ctl_q.ord)};

endmodule

// File: rtl/zbl_array.sv
module zbl_array #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES-1:0]        lane_en,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        initial begin
            for (int i = 0; i < DEPTH; i++) cells[i] = '0;
        end

        always_ff @(posedge clk) begin
            if (wr_en && lane_en[g]) cells[addr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rdata[g*LANE_W +: LANE_W] = cells[addr];
    end

endmodule

// File: rtl/zbl_bus.sv
module zbl_bus #(
    parameter int W = 36
) (
    inout  wire  [W-1:0] dq,
    input  logic         rd_drive,
    input  logic         oe_n,
    input  logic [W-1:0] rdata,
    output logic [W-1:0] din
);

    assign dq  = (rd_drive && !oe_n) ? rdata : {W{1'bz}};
    assign din = dq;

endmodule

// File: rtl/zbl_sram.sv
module zbl_sram
    import zbl_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = LANE_W_DEF
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clk_en_n,
    input  logic                    load_n,
    input  logic                    sel0_n,
    input  logic                    sel1,
    input  logic                    sel2_n,
    input  logic                    wr_n,
    input  logic [LANES-1:0]        bw_n,
    input  logic                    seq_lin,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    oe_n,
    inout  wire  [LANES*LANE_W-1:0] dq
);

    localparam int DATA_W = LANES * LANE_W;

    logic              op_valid;
    logic              op_write;
    logic [ADDR_W-1:0] op_addr;
    logic [LANES-1:0]  op_be;
    logic              rd_drive;
    logic              commit;
    logic [DATA_W-1:0] rdata;
    logic [DATA_W-1:0] din;

    zbl_seq #(.ADDR_W(ADDR_W), .LANES(LANES)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .clk_en_n (clk_en_n),
        .load_n   (load_n),
        .sel0_n   (sel0_n),
        .sel1     (sel1),
        .sel2_n   (sel2_n),
        .wr_n     (wr_n),
        .seq_lin  (seq_lin),
        .addr     (addr),
        .bw_n     (bw_n),
        .op_valid (op_valid),
        .op_write (op_write),
        .op_addr  (op_addr),
        .op_be    (op_be),
        .rd_drive (rd_drive)
    );

    // The write sampled at the previous edge lands now, alongside the next sample
    assign commit = !rst && !clk_en_n && op_valid && op_write;

    zbl_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk     (clk),
        .wr_en   (commit),
        .addr    (op_addr),
        .lane_en (op_be),
        .wdata   (din),
        .rdata   (rdata)
    );

    zbl_bus #(.W(DATA_W)) u_bus (
        .dq       (dq),
        .rd_drive (rd_drive),
        .oe_n     (oe_n),
        .rdata    (rdata),
        .din      (din)
    );

endmodule

// File: rtl/zbl_sram_chk.sv
module zbl_sram_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              clk_en_n,
    input logic              load_n,
    input logic              sel0_n,
    input logic              sel1,
    input logic              sel2_n,
    input logic              wr_n,
    input logic [ADDR_W-1:0] addr,
    input logic              op_valid,
    input logic              op_write,
    input logic [ADDR_W-1:0] op_addr,
    input logic              rd_drive
);

    logic pins_on;
    assign pins_on = !sel0_n && sel1 && !sel2_n;

    // R1: a selected load starts the requested operation at the given address
    a_r1_load_starts: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && !load_n && pins_on) |=>
            (op_valid && (op_write == $past(!wr_n)) && (op_addr == $past(addr))));

    // R3: a stalled edge changes no operation state
    a_r3_stall_hold: assert property (@(posedge clk) disable iff (rst)
        clk_en_n |=> ($stable(op_valid) && $stable(op_write) && $stable(op_addr)));

    // R4: a load without all selects leaves nothing active
    a_r4_deselect_idle: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && !load_n && !pins_on) |=> !op_valid);

    // R5: the read driver is never on during a write data cycle
    a_r5_write_no_drive: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_write) |-> !rd_drive);

    // R8: an advance keeps the operation kind and the upper address bits
    a_r8_advance_keeps: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && load_n && op_valid) |=>
            (op_valid && $stable(op_write) &&
             (op_addr[ADDR_W-1:2] == $past(op_addr[ADDR_W-1:2]))));

    // R10: reset clears the operation and the read driver
    a_r10_reset_clears: assert property (@(posedge clk)
        rst |=> (!op_valid && !rd_drive));

endmodule

bind zbl_sram zbl_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .clk_en_n (clk_en_n),
    .load_n   (load_n),
    .sel0_n   (sel0_n),
    .sel1     (sel1),
    .sel2_n   (sel2_n),
    .wr_n     (wr_n),
    .addr     (addr),
    .op_valid (op_valid),
    .op_write (op_write),
    .op_addr  (op_addr),
    .rd_drive (rd_drive)
);

// File: tb/tb_zbl_sram.sv
module tb_zbl_sram;

    localparam int AW = 8;
    localparam int DW = 36;

    localparam logic [2:0] ON   = 3'b010;
    localparam logic [2:0] OFF0 = 3'b110;
    localparam logic [2:0] OFF1 = 3'b000;
    localparam logic [2:0] OFF2 = 3'b011;

    localparam logic [1:0] NO  = 2'd0;
    localparam logic [1:0] VAL = 2'd1;
    localparam logic [1:0] FLT = 2'd2;

    localparam logic [DW-1:0] A  = 36'h1_2345_6789;
    localparam logic [DW-1:0] B  = 36'h9_8765_4321;
    localparam logic [DW-1:0] C  = 36'h7_FFFF_FFFF;
    localparam logic [DW-1:0] M  = 36'h7_F803_FE00;
    localparam logic [DW-1:0] E0 = 36'hA_0000_0001;
    localparam logic [DW-1:0] E1 = 36'hA_0000_0002;
    localparam logic [DW-1:0] E2 = 36'hA_0000_0003;
    localparam logic [DW-1:0] E3 = 36'hA_0000_0004;
    localparam logic [DW-1:0] J  = 36'h5_5555_5555;
    localparam logic [DW-1:0] G  = 36'h0_C0DE_0F0F;
    localparam logic [DW-1:0] FLOAT = {DW{1'b1}};

    typedef struct packed {
        logic          ld_n;
        logic [2:0]    ce;
        logic          wr_n;
        logic [3:0]    bw_n;
        logic          lin;
        logic [AW-1:0] addr;
        logic          drv;
        logic [DW-1:0] wd;
        logic [1:0]    chk;
        logic [DW-1:0] exp;
        logic [3:0]    req;
    } vec_t;

    // Each row: check the data cycle of the previous edge, drive its write data, present the next control
    localparam int NV = 32;
    localparam vec_t TAB [NV] = '{
        '{1'b0, ON,   1'b0, 4'h0, 1'b1, 8'h10, 1'b0, 36'h0, NO,  36'h0, 4'd1},  // R1 write 0x10
        '{1'b0, ON,   1'b0, 4'h0, 1'b1, 8'h11, 1'b1, A,     FLT, 36'h0, 4'd5},  // R5
        '{1'b0, ON,   1'b1, 4'h0, 1'b1, 8'h10, 1'b1, B,     NO,  36'h0, 4'd1},
        '{1'b0, ON,   1'b1, 4'h0, 1'b1, 8'h11, 1'b0, 36'h0, VAL, A,     4'd2},  // R2
        '{1'b0, ON,   1'b0, 4'h0, 1'b1, 8'h20, 1'b0, 36'h0, VAL, B,     4'd2},  // R2 read then write
        '{1'b0, ON,   1'b1, 4'h0, 1'b1, 8'h20, 1'b1, C,     FLT, 36'h0, 4'd5},  // R5
        '{1'b0, OFF0, 1'b1, 4'h0, 1'b1, 8'h20, 1'b0, 36'h0, VAL, C,     4'd2},  // R2 write then read
        '{1'b0, OFF1, 1'b1, 4'h0, 1'b1, 8'h20, 1'b0, 36'h0, FLT, 36'h0, 4'd4},  // R4
        '{1'b0, ON,   1'b0, 4'hA, 1'b1, 8'h20, 1'b0, 36'h0, FLT, 36'h0, 4'd4},  // R7 lanes 0,2
        '{1'b0, ON,   1'b1, 4'h0, 1'b1, 8'h20, 1'b1, 36'h0, FLT, 36'h0, 4'd5},
        '{1'b0, OFF2, 1'b1, 4'h0, 1'b1, 8'h20, 1'b0, 36'h0, VAL, M,     4'd7},  // R7
        '{1'b0, ON,   1'b0, 4'h0, 1'b1, 8'h42, 1'b0, 36'h0, FLT, 36'h0, 4'd4},  // R9 linear write burst
        '{1'b1, OFF1, 1'b1, 4'h0, 1'b1, 8'hFF, 1'b1, E0,    FLT, 36'h0, 4'd8},  // R8
        '{1'b1, OFF1, 1'b1, 4'h0, 1'b1, 8'hFF, 1'b1, E1,    FLT, 36'h0, 4'd8},
        '{1'b1, OFF1, 1'b1, 4'h0, 1'b1, 8'hFF, 1'b1, E2,    FLT, 36'h0, 4'd8},
        '{1'b0, ON,   1'b1, 4'h0, 1'b0, 8'h41, 1'b1, E3,    FLT, 36'h0, 4'd8},  // R9 interleaved read
        '{1'b1, OFF0, 1'b0, 4'h0, 1'b1, 8'hFF, 1'b0, 36'h0, VAL, E3,    4'd9},
        '{1'b1, OFF0, 1'b0, 4'h0, 1'b1, 8'hFF, 1'b0, 36'h0, VAL, E2,    4'd9},
        '{1'b1, OFF0, 1'b0, 4'h0, 1'b1, 8'hFF, 1'b0, 36'h0, VAL, E1,    4'd9},
        '{1'b0, OFF0, 1'b1, 4'h0, 1'b1, 8'h00, 1'b0, 36'h0, VAL, E0,    4'd4},  // R4 in-flight read completes
        '{1'b0, ON,   1'b1, 4'h0, 1'b1, 8'h40, 1'b0, 36'h0, FLT, 36'h0, 4'd4},
        '{1'b1, OFF1, 1'b1, 4'h0, 1'b1, 8'hFF, 1'b0, 36'h0, VAL, E2,    4'd9},
        '{1'b0, OFF2, 1'b1, 4'h0, 1'b1, 8'h00, 1'b0, 36'h0, VAL, E3,    4'd4},  // R4 burst stopped
        '{1'b1, ON,   1'b1, 4'h0, 1'b1, 8'h40, 1'b0, 36'h0, FLT, 36'h0, 4'd4},
        '{1'b1, ON,   1'b1, 4'h0, 1'b1, 8'h40, 1'b0, 36'h0, FLT, 36'h0, 4'd4},
        '{1'b0, ON,   1'b1, 4'h0, 1'b1, 8'h43, 1'b0, 36'h0, FLT, 36'h0, 4'd4},
        '{1'b1, OFF1, 1'b1, 4'h0, 1'b1, 8'hFF, 1'b0, 36'h0, VAL, E1,    4'd9},
        '{1'b1, OFF1, 1'b1, 4'h0, 1'b1, 8'hFF, 1'b0, 36'h0, VAL, E2,    4'd9},
        '{1'b1, OFF1, 1'b1, 4'h0, 1'b1, 8'hFF, 1'b0, 36'h0, VAL, E3,    4'd9},
        '{1'b1, OFF1, 1'b1, 4'h0, 1'b1, 8'hFF, 1'b0, 36'h0, VAL, E0,    4'd9},
        '{1'b0, OFF0, 1'b1, 4'h0, 1'b1, 8'h00, 1'b0, 36'h0, VAL, E1,    4'd8},  // R8 wrap
        '{1'b0, OFF0, 1'b1, 4'h0, 1'b1, 8'h00, 1'b0, 36'h0, FLT, 36'h0, 4'd4}
    };

    logic          clk = 1'b0;
    logic          rst;
    logic          clk_en_n, load_n, sel0_n, sel1, sel2_n, wr_n, seq_lin, oe_n;
    logic [3:0]    bw_n;
    logic [AW-1:0] addr;
    logic          tb_oe;
    logic [DW-1:0] tb_dq;
    tri1  [DW-1:0] dq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    assign dq = tb_oe ? tb_dq : {DW{1'bz}};

    always #5 clk = ~clk;

    zbl_sram #(.ADDR_W(AW), .LANES(4), .LANE_W(9)) dut (
        .clk(clk), .rst(rst), .clk_en_n(clk_en_n), .load_n(load_n),
        .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n), .wr_n(wr_n),
        .bw_n(bw_n), .seq_lin(seq_lin), .addr(addr), .oe_n(oe_n), .dq(dq)
    );

    task automatic check(input logic [DW-1:0] exp, input string tag);
        n_chk++;
        if (dq !== exp) begin
            n_bad++;
            $display("FAIL %s: dq=%h expected %h", tag, dq, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge
    task automatic cyc(input vec_t v, input logic hold, input string tag);
        if (v.chk == VAL) check(v.exp, tag);
        if (v.chk == FLT) check(FLOAT, tag);
        load_n  = v.ld_n;
        {sel0_n, sel1, sel2_n} = v.ce;
        wr_n    = v.wr_n;
        bw_n    = v.bw_n;
        seq_lin = v.lin;
        addr    = v.addr;
        clk_en_n = hold;
        tb_dq   = v.wd;
        tb_oe   = v.drv;
        @(posedge clk);
        #1 tb_oe = 1'b0;
        @(negedge clk);
    endtask

    function automatic vec_t mk(input logic ld_n, input logic [2:0] ce, input logic wr,
                                input logic [AW-1:0] a, input logic drv, input logic [DW-1:0] wd,
                                input logic [1:0] chk, input logic [DW-1:0] exp);
        vec_t v;
        v = '{ld_n, ce, wr, 4'h0, 1'b1, a, drv, wd, chk, exp, 4'd0};
        return v;
    endfunction

    initial begin
        #(10 * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; clk_en_n = 1'b0; load_n = 1'b1; sel0_n = 1'b1; sel1 = 1'b0;
        sel2_n = 1'b1; wr_n = 1'b1; bw_n = 4'h0; seq_lin = 1'b1; addr = '0;
        oe_n = 1'b0; tb_oe = 1'b0; tb_dq = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(FLOAT, "R10 reset state");
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            cyc(TAB[i], 1'b0, $sformatf("R%0d row %0d", TAB[i].req, i));
        end

        // R3: stall during a read, then during a write data cycle
        cyc(mk(1'b0, ON,   1'b1, 8'h10, 1'b0, 36'h0, FLT, 36'h0), 1'b0, "R3 idle");
        cyc(mk(1'b0, ON,   1'b0, 8'h11, 1'b0, 36'h0, VAL, A),     1'b1, "R3 read stalled");
        cyc(mk(1'b1, ON,   1'b1, 8'h00, 1'b0, 36'h0, VAL, A),     1'b1, "R3 read stalled");
        cyc(mk(1'b0, ON,   1'b0, 8'h30, 1'b0, 36'h0, VAL, A),     1'b0, "R3 read stalled");
        cyc(mk(1'b0, ON,   1'b1, 8'h11, 1'b1, J,     FLT, 36'h0), 1'b1, "R3 write stalled");
        cyc(mk(1'b0, ON,   1'b1, 8'h11, 1'b1, J,     FLT, 36'h0), 1'b1, "R3 write stalled");
        cyc(mk(1'b0, ON,   1'b1, 8'h30, 1'b1, G,     FLT, 36'h0), 1'b0, "R3 write stalled");
        cyc(mk(1'b0, ON,   1'b1, 8'h11, 1'b0, 36'h0, VAL, G),     1'b0, "R3 data after stall");
        cyc(mk(1'b0, OFF0, 1'b1, 8'h00, 1'b0, 36'h0, VAL, B),     1'b0, "R3 stalled load ignored");

        // R6: output enable acts without a clock edge
        cyc(mk(1'b0, ON,   1'b1, 8'h10, 1'b0, 36'h0, FLT, 36'h0), 1'b0, "R4 idle");
        check(A, "R2 read 0x10");
        oe_n = 1'b1;
        #1 check(FLOAT, "R6 oe_n high floats");
        oe_n = 1'b0;
        #1 check(A, "R6 oe_n low drives");

        // R10: reset wins over a stall and ends the read
        rst = 1'b1; clk_en_n = 1'b1; load_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(FLOAT, "R10 reset during stall");
        rst = 1'b0; clk_en_n = 1'b0;
        cyc(mk(1'b1, OFF0, 1'b1, 8'h00, 1'b0, 36'h0, FLT, 36'h0), 1'b0, "R10 no op after reset");
        check(FLOAT, "R10 advance after reset starts nothing");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule